// File: doc/BRIEF.md
# Distributed Shared-Bus Arbiter Node

This block is the arbitration slice that sits inside each processor sharing one external bus with up to five peers and one host. Every processor carries an identical copy. A strap ID tells the copy which request line it owns. The copy drives that one line low while it wants the bus and reads all six lines back from the wired bus. Every copy sees the same lines on the same clock edge and holds the same state, so all of them reach the same decision about the owner without any central arbiter.

A priority-mode input chooses the ordering. Fixed ordering always favours the lowest requesting ID. Rotating ordering starts the search just after the most recent owner. A host request overrides every processor. The node that last owned the bus then drops its bus enables and drives the host grant. A shared core-priority line lets a processor whose pending access comes from its core make DMA-driven requesters stand aside, including a master that is running DMA. A suspend input forces the bus enables off in the next cycle and stalls the local access for as long as it is held.

Top module: `mpa_arb_node`

## Requirements
- R1: For node_id 1 to 6 the node drives req_n_out low one cycle after a local request is sampled. Bit i of req_n_in carries the line of ID i+1. With node_id 0 the node never drives req_n_out or cpa_n_out low.
- R2: With rotate_en low, the lowest-numbered ID whose line is low becomes master two cycles after it raises its local request.
- R3: With rotate_en high, the search starts at the ID after the last owner and wraps from 6 to 1. After reset the last owner is taken to be ID 6.
- R4: A master keeps the bus while its own line stays low, whatever other lines do. When it releases its line, the next winner becomes master two cycles after that release.
- R5: When host_req_n is sampled low, the next cycle has no master and no bus_oe on any node. host_grant_n is driven low only by the last owner, which is ID 6 if no node has owned the bus since reset. The grant is released one cycle after host_req_n returns high.
- R6: A non-master with a core request (local_is_core high) pulls cpa_n_out low. While the shared line is low, DMA requesters, including a DMA master, release their lines. The core requester therefore gets the bus and keeps it after the DMA node asks again.
- R7: When suspend_n is sampled low, bus_oe is low in the next cycle and access_stall is high while the local request remains. Both recover one cycle after suspend_n returns high.
- R8: At most one node is master at any time, and bus_oe is high only on the master.
- R9: A node with node_id 0 is master whenever no host holds the bus, and it drives the host grant itself.
- R10: After reset no node is master, every request line and grant is high, and every bus_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | ID_W | Strap ID. 0 means a lone processor. |
| rotate_en | input | 1 | 1 selects rotating order, 0 selects fixed order |
| local_req | input | 1 | Local side wants the bus |
| local_is_core | input | 1 | The pending access comes from the core, not DMA |
| req_n_in | input | NODES | All request lines read back from the bus, active low |
| host_req_n | input | 1 | Host request, active low |
| cpa_n_in | input | 1 | Shared core-priority line, active low |
| suspend_n | input | 1 | Suspend bus drive, active low |
| req_n_out | output | 1 | This node's request line drive, active low |
| cpa_n_out | output | 1 | Core-priority drive, active low |
| host_grant_n | output | 1 | Host grant drive, active low |
| is_master | output | 1 | This node owns the bus |
| bus_oe | output | 1 | Enable for the address, data, select and strobe drivers |
| access_stall | output | 1 | The local access must wait |

## Verification
The assertions assume that node_id is a constant strap, that rotate_en changes only while every node is in reset, and that the six lines on req_n_in are exactly the req_n_out drives of six peers with distinct IDs. The bench respects these assumptions. It wires six nodes with IDs 1 to 6 into one bus, adds a separate lone node with ID 0, and changes rotate_en only while reset is held. Each request pattern is applied from an idle bus, so the last owner follows from the previous winner alone.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  localparam int MPA_NODES = 6;
  localparam int MPA_ID_W  = $clog2(MPA_NODES + 1);
endpackage

// File: rtl/mpa_pick.sv
module mpa_pick #(
  parameter int NODES = mpa_pkg::MPA_NODES,
  parameter int ID_W  = mpa_pkg::MPA_ID_W
) (
  input  logic [NODES-1:0] req_vec,
  input  logic             rotate,
  input  logic [ID_W-1:0]  last_id,
  output logic [ID_W-1:0]  win_id
);
  int start;

  always_comb begin
    start  = rotate ? (int'(last_id) % NODES) : 0;
    win_id = '0;
    for (int k = NODES - 1; k >= 0; k--) begin
      if (req_vec[(start + k) % NODES]) win_id = ID_W'(((start + k) % NODES) + 1);
    end
  end
endmodule

// File: rtl/mpa_line_drv.sv
module mpa_line_drv (
  input  logic clk,
  input  logic rst,
  input  logic solo,
  input  logic local_req,
  input  logic local_is_core,
  input  logic is_master,
  input  logic cpa_line_n,
  output logic req_n,
  output logic cpa_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_n <= 1'b1;
      cpa_n <= 1'b1;
    end else begin
      req_n <= !(local_req && !solo && (local_is_core || cpa_line_n));
      cpa_n <= !(local_req && !solo && local_is_core && !is_master);
    end
  end
endmodule

// File: rtl/mpa_arb_node.sv
module mpa_arb_node #(
  parameter int NODES = mpa_pkg::MPA_NODES,
  parameter int ID_W  = mpa_pkg::MPA_ID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  node_id,
  input  logic             rotate_en,
  input  logic             local_req,
  input  logic             local_is_core,
  input  logic [NODES-1:0] req_n_in,
  input  logic             host_req_n,
  input  logic             cpa_n_in,
  input  logic             suspend_n,
  output logic             req_n_out,
  output logic             cpa_n_out,
  output logic             host_grant_n,
  output logic             is_master,
  output logic             bus_oe,
  output logic             access_stall
);
  localparam logic [ID_W-1:0] LAST_RST = ID_W'(NODES);

  logic [ID_W-1:0]  owner_q, owner_d, last_q, last_d, win_id;
  logic             host_q, host_d, master_d, grant_q, solo, owner_holds;
  logic [NODES-1:0] req_vec;

  assign solo    = (node_id == '0);
  assign req_vec = ~req_n_in;

  mpa_pick #(.NODES(NODES), .ID_W(ID_W)) u_pick (
    .req_vec(req_vec), .rotate(rotate_en), .last_id(last_q), .win_id(win_id)
  );

  mpa_line_drv u_drv (
    .clk(clk), .rst(rst), .solo(solo), .local_req(local_req),
    .local_is_core(local_is_core), .is_master(is_master),
    .cpa_line_n(cpa_n_in), .req_n(req_n_out), .cpa_n(cpa_n_out)
  );

  always_comb begin
    owner_holds = 1'b0;
    for (int i = 0; i < NODES; i++) begin
      if (owner_q == ID_W'(i + 1) && req_vec[i]) owner_holds = 1'b1;
    end
    host_d = !host_req_n;
    if (host_d)           owner_d = '0;
    else if (owner_holds) owner_d = owner_q;
    else                  owner_d = win_id;
    last_d   = (owner_d != '0) ? owner_d : last_q;
    master_d = solo ? !host_d : (owner_d == node_id);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q      <= '0;
      last_q       <= LAST_RST;
      host_q       <= 1'b0;
      grant_q      <= 1'b0;
      is_master    <= 1'b0;
      bus_oe       <= 1'b0;
      access_stall <= 1'b0;
    end else begin
      owner_q      <= owner_d;
      last_q       <= last_d;
      host_q       <= host_d;
      grant_q      <= host_d && (solo || last_d == node_id);
      is_master    <= master_d;
      bus_oe       <= master_d && suspend_n;
      access_stall <= local_req && !(master_d && suspend_n);
    end
  end

  assign host_grant_n = !grant_q;
endmodule

// File: rtl/mpa_arb_node_chk.sv
module mpa_arb_node_chk #(
  parameter int NODES = 6,
  parameter int ID_W  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [ID_W-1:0] node_id,
  input logic            local_req,
  input logic            local_is_core,
  input logic            host_req_n,
  input logic            suspend_n,
  input logic            req_n_out,
  input logic            cpa_n_out,
  input logic            host_grant_n,
  input logic            is_master,
  input logic            bus_oe,
  input logic            access_stall
);
  // R8
  oe_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> is_master);
  // R5
  host_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !host_req_n |=> (!is_master && !bus_oe));
  // R5
  grant_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    !host_grant_n |-> $past(!host_req_n));
  // R7
  suspend_drops_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !suspend_n |=> !bus_oe);
  // R7
  suspend_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (local_req && !suspend_n) |=> access_stall);
  // R1
  solo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (node_id == '0) |=> (req_n_out && cpa_n_out));
  // R1
  core_line_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (node_id != '0 && local_req && local_is_core) |=> !req_n_out);
endmodule

bind mpa_arb_node mpa_arb_node_chk #(.NODES(NODES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .node_id(node_id), .local_req(local_req),
  .local_is_core(local_is_core), .host_req_n(host_req_n), .suspend_n(suspend_n),
  .req_n_out(req_n_out), .cpa_n_out(cpa_n_out), .host_grant_n(host_grant_n),
  .is_master(is_master), .bus_oe(bus_oe), .access_stall(access_stall)
);

// File: tb/tb_mpa_arb_node.sv
module tb_mpa_arb_node;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rot = 1'b0;
  logic host_n = 1'b1;
  logic susp_n = 1'b1;
  logic [N-1:0] lreq = '0;
  logic [N-1:0] lcore = '0;
  logic [N-1:0] rq_n, cp_n, hg_n, ism, oe, st;
  logic cpa_bus;
  logic grant_bus;
  logic solo_req = 1'b0;
  logic s_rq, s_cp, s_hg, s_m, s_oe, s_st;
  int errs = 0;
  int checks = 0;
  logic mon_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign cpa_bus   = &cp_n;
  assign grant_bus = &hg_n;

  mpa_arb_node dut (
    .clk(clk), .rst(rst), .node_id(3'd1), .rotate_en(rot), .local_req(lreq[0]),
    .local_is_core(lcore[0]), .req_n_in(rq_n), .host_req_n(host_n), .cpa_n_in(cpa_bus),
    .suspend_n(susp_n), .req_n_out(rq_n[0]), .cpa_n_out(cp_n[0]), .host_grant_n(hg_n[0]),
    .is_master(ism[0]), .bus_oe(oe[0]), .access_stall(st[0])
  );

  for (genvar g = 1; g < N; g++) begin : gen_peer
    mpa_arb_node peer (
      .clk(clk), .rst(rst), .node_id(3'(g + 1)), .rotate_en(rot), .local_req(lreq[g]),
      .local_is_core(lcore[g]), .req_n_in(rq_n), .host_req_n(host_n), .cpa_n_in(cpa_bus),
      .suspend_n(susp_n), .req_n_out(rq_n[g]), .cpa_n_out(cp_n[g]), .host_grant_n(hg_n[g]),
      .is_master(ism[g]), .bus_oe(oe[g]), .access_stall(st[g])
    );
  end

  mpa_arb_node solo (
    .clk(clk), .rst(rst), .node_id(3'd0), .rotate_en(1'b0), .local_req(solo_req),
    .local_is_core(1'b1), .req_n_in({N{1'b1}}), .host_req_n(host_n), .cpa_n_in(1'b1),
    .suspend_n(1'b1), .req_n_out(s_rq), .cpa_n_out(s_cp), .host_grant_n(s_hg),
    .is_master(s_m), .bus_oe(s_oe), .access_stall(s_st)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  function automatic int pick(input int p, input bit r, input int last);
    for (int k = 1; k <= N; k++) begin
      int id;
      id = r ? ((last - 1 + k) % N) + 1 : k;
      if (p[id-1]) return id;
    end
    return 0;
  endfunction

  // R8: at most one master, oe only on master, checked every cycle
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      check("R8 masters<=1", int'($countones(ism) <= 1), 1);
      check("R8 oe subset of master", int'(oe & ~ism), 0);
    end
  end

  initial begin
    do_reset();
    // R10
    check("R10 no master", int'(ism), 0);
    check("R10 lines high", int'(rq_n), 63);
    check("R10 grant high", int'(grant_bus), 1);
    check("R10 oe low", int'(oe), 0);
    mon_on = 1'b1;

    // R2 fixed / R3 rotating sweeps over every request pattern
    for (int m = 0; m < 2; m++) begin
      int last;
      rst = 1'b1;
      rot = m[0];
      step(2);
      rst = 1'b0;
      step(1);
      last = N;
      for (int p = 0; p < 64; p++) begin
        int w, expv;
        lreq = N'(p);
        step(2);
        w = pick(p, m[0], last);
        expv = (w == 0) ? 0 : (1 << (w - 1));
        check(m == 0 ? "R2 fixed winner" : "R3 rotating winner", int'(ism), expv);
        step(2);
        check("R4 winner holds", int'(ism), expv);
        if (w != 0) last = w;
        lreq = '0;
        step(3);
      end
    end

    // R4 master not displaced by higher-priority ID
    rst = 1'b1; rot = 1'b0; step(2); rst = 1'b0; step(1);
    lreq = 6'b001000;
    step(2);
    check("R4 node4 master", int'(ism), 8);
    lreq = 6'b001001;
    step(4);
    check("R4 node4 keeps bus", int'(ism), 8);
    lreq = 6'b000001;
    step(2);
    check("R4 handover to node1", int'(ism), 1);

    // R5 host takeover, grant driven by last owner (node1)
    host_n = 1'b0;
    step(1);
    check("R5 no master under host", int'(ism), 0);
    check("R5 oe off", int'(oe), 0);
    check("R5 grant low", int'(grant_bus), 0);
    check("R5 grant from last owner", int'(hg_n), 62);
    step(3);
    check("R5 grant held", int'(grant_bus), 0);
    host_n = 1'b1;
    step(1);
    check("R5 grant released", int'(grant_bus), 1);
    check("R5 node1 back", int'(ism), 1);

    // R7 suspend
    check("R7 oe before", int'(oe[0]), 1);
    susp_n = 1'b0;
    step(1);
    check("R7 oe off", int'(oe[0]), 0);
    check("R7 stall", int'(st[0]), 1);
    step(2);
    check("R7 still stalled", int'(st[0]), 1);
    susp_n = 1'b1;
    step(1);
    check("R7 oe back", int'(oe[0]), 1);
    check("R7 stall cleared", int'(st[0]), 0);
    lreq = '0;
    step(3);

    // R5 grant from ID6 when nobody owned since reset
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    host_n = 1'b0;
    step(1);
    check("R5 reset grant from ID6", int'(hg_n), 31);
    host_n = 1'b1;
    step(2);

    // R6 core priority pre-empts DMA master
    lreq = 6'b000010; lcore = '0;
    step(2);
    check("R6 node2 DMA master", int'(ism), 2);
    lreq = 6'b010010; lcore = 6'b010000;
    step(1);
    check("R6 cpa asserted", int'(cpa_bus), 0);
    step(2);
    check("R6 core node5 wins", int'(ism), 16);
    step(4);
    check("R6 node5 keeps", int'(ism), 16);
    check("R6 cpa released", int'(cpa_bus), 1);
    check("R6 DMA node re-requests", int'(rq_n[1]), 0);
    lreq = '0; lcore = '0;
    step(3);

    // R1 line timing and R9 single-processor node
    lreq = 6'b000100;
    step(1);
    check("R1 own line low", int'(rq_n), 59);
    solo_req = 1'b1;
    step(2);
    check("R9 solo master", int'(s_m), 1);
    check("R9 solo oe", int'(s_oe), 1);
    check("R1 solo line idle", int'(s_rq), 1);
    host_n = 1'b0;
    step(1);
    check("R9 solo grants host", int'(s_hg), 0);
    check("R9 solo yields", int'(s_m), 0);
    host_n = 1'b1;
    step(1);
    check("R9 solo regains", int'(s_m), 1);

    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule